// File: doc/BRIEF.md
# Transmit Complete Flag Logic

This block decides when a serial transmitter is fully idle. It watches four activity indicators from the transmit datapath: the transmit queue not being empty, the shift register busy, a preamble being sent and a break character being sent. It keeps one registered flag that reads 1 only when none of these has been active since the last clearing event. While the flag is high, the block forces the serial output to the idle level of logic 1. While the flag is low, the line carries the transmitter's own serial bit.

Software clears the flag in two steps. First it reads the status while the flag is high, which arms the clear. Then it performs one of three starting actions: a data write, re-enabling the transmitter (enable low, then high), or a rising write of the send-break control. The block turns the last two into one-cycle start pulses for the frame state machine. The frame state machine is outside this block. A starting action without an armed read still produces its pulse. In that case the flag falls only once the transmitter reports activity.

This block has no streaming data path. Every pin is a plain level or a one-cycle strobe sampled on the rising clock edge, so there is no back-pressure.

Top module: `tx_complete_flag`

## Requirements
- R1: During and right after reset the flag is 1, and the serial output is 1 whatever the transmitter's serial bit is.
- R2: If any activity indicator is high at a clock edge (queue empty low, shifter busy, preamble active or break active), the flag is 0 after that edge.
- R3: If all indicators are idle at an edge and no armed clear is still waiting for activity, the flag is 1 after that edge.
- R4: The serial output equals 1 while the flag is 1, and equals the transmitter's serial bit while the flag is 0.
- R5: A status read sampled while the flag is 1 arms the clear. A data write at a later edge while still armed makes the flag 0 after that edge, even if the transmitter is idle.
- R6: When the transmit enable is 1 in a cycle after being 0 in the previous cycle (0 after reset), the preamble start output is 1 in that cycle, and this counts as a starting action for R5.
- R7: When the send-break control is 1 in a cycle after being 0 in the previous cycle (0 after reset), the break start output is 1 in that cycle, and this counts as a starting action for R5.
- R8: A starting action with no armed read leaves the flag at 1 while all indicators stay idle.
- R9: A status read in the same cycle as a starting action does not arm it. Arming is discarded whenever the flag falls.
- R10: After an armed clear, the flag stays 0 while the indicators are idle, until at least one indicator has been seen high. After that it follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| txq_empty | input | 1 | Transmit queue holds no words |
| shift_busy | input | 1 | Shift register is sending a frame, stop bit included |
| pre_active | input | 1 | Preamble being sent |
| brk_active | input | 1 | Break character being sent |
| stat_rd | input | 1 | One-cycle strobe: status was read |
| data_wr | input | 1 | One-cycle strobe: data was written |
| tx_en | input | 1 | Transmit enable level |
| send_brk | input | 1 | Send-break control level |
| ser_in | input | 1 | Serial bit from the frame state machine |
| done_flag | output | 1 | Transmit complete flag |
| pre_start | output | 1 | One-cycle pulse: queue a preamble |
| brk_start | output | 1 | One-cycle pulse: queue a break |
| ser_out | output | 1 | Serial line output |

## Verification
The bench goes after the window between an armed clear and the first activity. A design that lets the flag rise again there would report completion before the frame has started. It also drives a status read in the same cycle as a write. A design that arms on that read would clear the flag with no prior read. It checks that arming is dropped when activity ends the flag on its own, since a stale arm would let a later plain write clear the flag. It also drives enable and break levels that stay high for several cycles, where a level-sensitive decode would pulse again on every cycle.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  localparam int unsigned NUM_IND = 4;

  typedef struct packed {
    logic wr;
    logic pre;
    logic brk;
  } tcf_act_t;
endpackage

// File: rtl/tcf_act_decode.sv
module tcf_act_decode
  import tcf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     data_wr,
  input  logic     tx_en,
  input  logic     send_brk,
  output tcf_act_t act,
  output logic     any_act
);
  logic en_q;
  logic brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      en_q  <= tx_en;
      brk_q <= send_brk;
    end
  end

  always_comb begin
    act.wr  = data_wr;
    act.pre = tx_en & ~en_q;
    act.brk = send_brk & ~brk_q;
    any_act = act.wr | act.pre | act.brk;
  end
endmodule

// File: rtl/tcf_activity.sv
module tcf_activity #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] ind,
  output logic         busy
);
  localparam int unsigned LAST = N - 1;
  logic [LAST:0] chain;

  generate
    for (genvar i = 0; i < N; i++) begin : g_or
      if (i == 0) begin : g_first
        assign chain[i] = ind[i];
      end else begin : g_next
        assign chain[i] = chain[i-1] | ind[i];
      end
    end
  endgenerate

  assign busy = chain[LAST];
endmodule

// File: rtl/tcf_flag_ctrl.sv
module tcf_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic stat_rd,
  input  logic any_act,
  output logic flag,
  output logic armed,
  output logic waiting
);
  logic arm_clear;
  logic wait_n;
  logic flag_n;
  logic armed_n;

  always_comb begin
    arm_clear = armed & any_act;
    if (busy)           wait_n = 1'b0;
    else if (arm_clear) wait_n = 1'b1;
    else                wait_n = waiting;
    flag_n  = ~busy & ~wait_n;
    armed_n = flag_n & (armed | (stat_rd & flag));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b1;
      armed   <= 1'b0;
      waiting <= 1'b0;
    end else begin
      flag    <= flag_n;
      armed   <= armed_n;
      waiting <= wait_n;
    end
  end
endmodule

// File: rtl/tx_complete_flag.sv
module tx_complete_flag
  import tcf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic txq_empty,
  input  logic shift_busy,
  input  logic pre_active,
  input  logic brk_active,
  input  logic stat_rd,
  input  logic data_wr,
  input  logic tx_en,
  input  logic send_brk,
  input  logic ser_in,
  output logic done_flag,
  output logic pre_start,
  output logic brk_start,
  output logic ser_out
);
  tcf_act_t           act;
  logic               any_act;
  logic               busy;
  logic               armed;
  logic               waiting;
  logic [NUM_IND-1:0] ind;

  assign ind = {brk_active, pre_active, shift_busy, ~txq_empty};

  tcf_act_decode u_dec (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .tx_en(tx_en),
    .send_brk(send_brk), .act(act), .any_act(any_act)
  );

  tcf_activity #(.N(NUM_IND)) u_act (.ind(ind), .busy(busy));

  tcf_flag_ctrl u_flag (
    .clk(clk), .rst_n(rst_n), .busy(busy), .stat_rd(stat_rd),
    .any_act(any_act), .flag(done_flag), .armed(armed), .waiting(waiting)
  );

  assign pre_start = act.pre;
  assign brk_start = act.brk;
  assign ser_out   = done_flag | ser_in;
endmodule

// File: rtl/tx_complete_flag_chk.sv
module tx_complete_flag_chk (
  input logic clk,
  input logic rst_n,
  input logic txq_empty,
  input logic shift_busy,
  input logic pre_active,
  input logic brk_active,
  input logic data_wr,
  input logic tx_en,
  input logic send_brk,
  input logic ser_in,
  input logic done_flag,
  input logic pre_start,
  input logic brk_start,
  input logic ser_out,
  input logic armed
);
  logic act_seen;
  assign act_seen = ~txq_empty | shift_busy | pre_active | brk_active;

  a_r2_active_clears: assert property (@(posedge clk) disable iff (!rst_n)
    act_seen |=> !done_flag);

  a_r4_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag |-> ser_out);

  a_r4_line_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !done_flag |-> (ser_out == ser_in));

  a_r5_armed_write: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && data_wr) |=> !done_flag);

  a_r6_pre_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start |-> tx_en);

  a_r7_brk_needs_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    brk_start |-> send_brk);

  a_r9_arm_only_when_set: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> done_flag);
endmodule

bind tx_complete_flag tx_complete_flag_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txq_empty(txq_empty), .shift_busy(shift_busy),
  .pre_active(pre_active), .brk_active(brk_active), .data_wr(data_wr),
  .tx_en(tx_en), .send_brk(send_brk), .ser_in(ser_in), .done_flag(done_flag),
  .pre_start(pre_start), .brk_start(brk_start), .ser_out(ser_out),
  .armed(armed)
);

// File: tb/test_tx_complete_flag.sv
`timescale 1ns/1ps
module test_tx_complete_flag;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txq_empty = 1'b1, shift_busy = 1'b0, pre_active = 1'b0, brk_active = 1'b0;
  logic stat_rd = 1'b0, data_wr = 1'b0, tx_en = 1'b0, send_brk = 1'b0, ser_in = 1'b0;
  logic done_flag, pre_start, brk_start, ser_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  bit m_flag = 1, m_armed = 0, m_wait = 0, m_en_q = 0, m_brk_q = 0;

  always #4 clk = ~clk;

  tx_complete_flag i_tx_complete_flag (
    .clk(clk), .rst_n(rst_n), .txq_empty(txq_empty), .shift_busy(shift_busy),
    .pre_active(pre_active), .brk_active(brk_active), .stat_rd(stat_rd),
    .data_wr(data_wr), .tx_en(tx_en), .send_brk(send_brk), .ser_in(ser_in),
    .done_flag(done_flag), .pre_start(pre_start), .brk_start(brk_start),
    .ser_out(ser_out)
  );

  function automatic bit f_busy();
    return !txq_empty || shift_busy || pre_active || brk_active;
  endfunction

  function automatic bit f_pre();
    return tx_en && !m_en_q;
  endfunction

  function automatic bit f_brk();
    return send_brk && !m_brk_q;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: inputs already driven after negedge
  task automatic step();
    bit b, a, wn, fn;
    string tag;
    #1;
    check("R6 preamble pulse", pre_start, f_pre());
    check("R7 break pulse", brk_start, f_brk());
    check("R4 line", ser_out, m_flag ? 1'b1 : ser_in);
    b  = f_busy();
    a  = m_armed && (data_wr || f_pre() || f_brk());
    wn = b ? 1'b0 : (a ? 1'b1 : m_wait);
    fn = !b && !wn;
    if (b) tag = "R2 flag";
    else if (a) tag = "R5 flag";
    else if (m_wait) tag = "R10 flag";
    else tag = "R3 flag";
    m_armed = fn && (m_armed || (stat_rd && m_flag));
    m_flag  = fn;
    m_wait  = wn;
    m_en_q  = tx_en;
    m_brk_q = send_brk;
    @(posedge clk);
    #1;
    check(tag, done_flag, m_flag);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    txq_empty = 1; shift_busy = 0; pre_active = 0; brk_active = 0;
    stat_rd = 0; data_wr = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int unsigned r;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    ser_in = 0;
    #1;
    check("R1 reset flag", done_flag, 1'b1);
    check("R1 reset line", ser_out, 1'b1);
    rst_n = 1;
    @(negedge clk);

    // R8: write without arming keeps flag
    idle_inputs(); data_wr = 1; step();
    idle_inputs(); step();
    check("R8 unarmed write", done_flag, 1'b1);

    // R9: read in same cycle as write does not arm
    stat_rd = 1; data_wr = 1; step();
    idle_inputs(); step();
    check("R9 same-cycle read", done_flag, 1'b1);

    // R5 then R10 then R3
    stat_rd = 1; step();
    idle_inputs(); data_wr = 1; step();
    check("R5 armed write clears", done_flag, 1'b0);
    idle_inputs();
    for (int i = 0; i < 3; i++) step();
    check("R10 waits for activity", done_flag, 1'b0);
    shift_busy = 1; ser_in = 0; step();
    check("R4 line follows", ser_out, 1'b0);
    idle_inputs(); step();
    check("R3 idle sets", done_flag, 1'b1);

    // R6: enable toggle after arm
    stat_rd = 1; step();
    idle_inputs(); step();
    tx_en = 1; #1;
    check("R6 pulse", pre_start, 1'b1);
    step();
    check("R6 clears", done_flag, 1'b0);
    step();
    check("R6 single pulse", pre_start, 1'b0);
    pre_active = 1; step();
    idle_inputs(); step();
    check("R3 after preamble", done_flag, 1'b1);

    // R7: break request after arm
    stat_rd = 1; step();
    idle_inputs(); send_brk = 1; #1;
    check("R7 pulse", brk_start, 1'b1);
    step();
    check("R7 clears", done_flag, 1'b0);
    brk_active = 1; step();
    send_brk = 0; idle_inputs(); step();

    // R9: arm dropped by activity
    stat_rd = 1; step();
    idle_inputs(); txq_empty = 0; step();
    idle_inputs(); step();
    data_wr = 1; step();
    idle_inputs(); step();
    check("R9 arm discarded", done_flag, 1'b1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      r = $urandom();
      txq_empty  = (r[2:0] != 0);
      shift_busy = (r[6:3] == 0);
      pre_active = (r[10:7] == 0);
      brk_active = (r[14:11] == 0);
      stat_rd    = (r[16:15] == 0);
      data_wr    = (r[19:17] == 0);
      if (r[23:20] == 0) tx_en = ~tx_en;
      if (r[26:24] == 0) send_brk = ~send_brk;
      ser_in     = r[27];
      step();
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule